// File: doc/BRIEF.md
# Interrupt Priority and Delivery Sequencer

This block decides which interruption class a processor core takes next and then carries out the delivery through memory. A delivery pass starts when the core pulses `take_i`. The block then picks one class from the inputs it sees on that edge:

- a synchronous program exception or supervisor call, if one is present;
- otherwise one of three asynchronous classes (machine check, external, I/O), each gated by its own enable bit from the status word.

Inside the external class the block can make up timer codes itself. Inside the I/O class it scans eight subclasses, each with its own enable. The block reports the chosen class and code, and pulses "pop" and "clear" strobes so that the owner of the pending flags and queue counters can update them.

For a class it actually delivers, the block runs a short memory sequence in fixed low-memory slots:

1. write an interruption-parameter word;
2. write the old status-word mask, with the condition code merged in;
3. write the old instruction address;
4. read the new mask;
5. read the new address.

When the new status word is ready, `done_o` pulses. A pass that finds nothing to deliver pulses `done_o` on the cycle after the take, with the class reported as none.

The memory request channel is valid/ready. While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the address, write data and write flag stay stable, and the request is not withdrawn. A read response is offered with `mem_rvalid_i` and is taken on a cycle where `mem_rready_o` is high. `mem_rready_o` is high only while a read response is awaited. A take that arrives while a sequence is in flight is ignored.

Top module: `irq_delivery_seq`

## Requirements
- R1: On an accepted take, the class is chosen in this order: program exception, supervisor call, machine check (if `en_mchk_i` and `pend_mchk_i`), external (if `en_ext_i` and there is something to deliver), I/O (if `en_io_i` and `pend_io_i`). The result appears on `sel_class_o` in the cycle after the take, encoded as none=0, program=1, supervisor call=2, machine check=3, external=4, I/O=5.
- R2: Within the external class, the order is as follows. A queued entry (`pend_ext_i` with a nonzero `ext_cnt_i`) wins, with code `ext_code_i`. Otherwise a pending clock-comparator event gives code 0x1004. Otherwise a pending CPU-timer event gives code 0x1005. Both timer cases pulse `clr_ext_o` and `clr_tod_o`, and neither pops the queue.
- R3: The I/O class delivers the lowest-numbered subclass k that has a nonzero count and is enabled. Subclass k is enabled by `io_enable_i[NSUB-1-k]`, so the MSB belongs to subclass 0. `sel_code_o` is k, and exactly bit k of `io_pop_o` pulses. One subclass is delivered per pass.
- R4: `clr_io_o` pulses on an I/O-class pass only when no subclass holds entries after this pass's pop. Masked-off subclasses with entries count as holding entries. If no subclass qualifies, nothing is delivered.
- R5: When the machine check is chosen but `mchk_gate_i` (bit 28 of control register 14) is low, nothing is delivered, nothing is popped or cleared, and no lower class is tried.
- R6: A delivery from a queued class pulses that class's pop strobe for one cycle. It also pulses that class's clear strobe when the count was 1, meaning the queue index falls to -1.
- R7: The stored old mask equals `sw_mask_i` with bits 45:44 replaced by `cc_i`.
- R8: For a supervisor call, the stored old address is `sw_addr_i + svc_len_i`. The parameter word is {32'b0, length[15:0], code[15:0]}.
- R9: The program length code 2, 4 or 6 is used as is. Code 0 takes the length from `opc_top_i` (00 gives 2, 01 and 10 give 4, 11 gives 6). Code 1 does the same and also adds that length to the stored address. The parameter word has the same layout as in R8.
- R10: The external parameter word is {16'b0, cpu_num_i|0x0D00, 16'b0, code}. The I/O word is the subclass number in bits 15:0. The machine-check word is 0x00400F1D_40330000.
- R11: `irq_req_o` is high exactly when any of the five pending flags is high.
- R12: The class base is LOW_BASE + class*0x40. The sequence writes the parameter word at +0x00, the old mask at +0x08 and the old address at +0x10, then reads the new mask at +0x18 and the new address at +0x20. `done_o` pulses once, with `new_mask_o` and `new_addr_o` holding the words read.
- R13: A stalled request holds its address, data and write flag. A take during a sequence changes nothing.
- R14: After reset, `sel_class_o` is none, and `done_o`, `mem_req_valid_o` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Start a delivery pass |
| pgm_exc_i | input | 1 | Synchronous program exception present |
| pgm_code_i | input | 16 | Program interruption code |
| pgm_len_i | input | 3 | Program length code (0, 1, 2, 4, 6) |
| opc_top_i | input | 2 | Two most significant opcode bits |
| svc_exc_i | input | 1 | Supervisor call present |
| svc_code_i | input | 16 | Supervisor call number |
| svc_len_i | input | 3 | Supervisor call instruction length |
| sw_mask_i | input | 64 | Current status-word mask |
| sw_addr_i | input | 64 | Current instruction address |
| cc_i | input | 2 | Current condition code |
| en_mchk_i | input | 1 | Machine-check enable from the status word |
| en_ext_i | input | 1 | External enable from the status word |
| en_io_i | input | 1 | I/O enable from the status word |
| pend_mchk_i | input | 1 | Machine check pending |
| pend_ext_i | input | 1 | Queued external pending |
| pend_tod_i | input | 1 | Clock-comparator event pending |
| pend_cpt_i | input | 1 | CPU-timer event pending |
| pend_io_i | input | 1 | I/O pending |
| io_enable_i | input | NSUB | Subclass enables, MSB is subclass 0 |
| mchk_gate_i | input | 1 | Control register 14 bit 28 |
| mchk_cnt_i | input | CW | Machine-check queue count |
| ext_cnt_i | input | CW | External queue count |
| io_cnt_i | input | NSUB*CW | Per-subclass counts, subclass k at [k*CW +: CW] |
| ext_code_i | input | 16 | Code of the head external entry |
| cpu_num_i | input | 8 | CPU number |
| irq_req_o | output | 1 | Request line to the core |
| sel_class_o | output | 3 | Chosen class of the last pass |
| sel_code_o | output | 16 | Chosen code of the last pass |
| mchk_pop_o | output | 1 | Machine-check queue pop strobe |
| ext_pop_o | output | 1 | External queue pop strobe |
| io_pop_o | output | NSUB | Per-subclass pop strobes |
| clr_mchk_o | output | 1 | Clear machine-check pending |
| clr_ext_o | output | 1 | Clear external pending |
| clr_tod_o | output | 1 | Clear clock-comparator pending |
| clr_io_o | output | 1 | Clear I/O pending |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request ready |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rready_o | output | 1 | Read response accepted |
| mem_rdata_i | input | 64 | Read response data |
| done_o | output | 1 | Pass complete pulse |
| new_mask_o | output | 64 | New status-word mask read |
| new_addr_o | output | 64 | New instruction address read |

## Verification
A table walks the class choice through several kinds of input pattern:

- everything pending at once with different enables cleared, which separates the fixed class order from the per-class masks;
- a gated machine check above lower classes, which shows that the pass stops rather than falling through;
- each external source on its own, which separates the synthesized timer codes from the queued code;
- I/O subclass sets mixing masked and unmasked subclasses with counts of one and two, which separates the lowest-enabled scan from the pending-clear rule.

Directed passes then read back the memory slots. They cover each program length code and opcode length, the supervisor-call address step, the CPU-address tag and the merged condition code. A stalled memory port checks that the request holds steady and that a second take is ignored.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_PGM  = 3'd1,
    CLS_SVC  = 3'd2,
    CLS_MCHK = 3'd3,
    CLS_EXT  = 3'd4,
    CLS_IO   = 3'd5
  } irq_cls_e;

  localparam logic [15:0] CODE_CLKCMP  = 16'h1004;
  localparam logic [15:0] CODE_CPUTMR  = 16'h1005;
  localparam logic [15:0] CPU_ADDR_TAG = 16'h0D00;
  localparam logic [63:0] MCHK_PARAM   = 64'h00400F1D_40330000;
  localparam int          CC_LSB       = 44;
  localparam int          SLOT_STRIDE  = 64;
  localparam logic [2:0]  LEN_DEFER     = 3'd0;
  localparam logic [2:0]  LEN_DEFER_INC = 3'd1;

  typedef struct packed {
    irq_cls_e    cls;
    logic [15:0] code;
    logic        deliver;
    logic        pop_ext;
    logic        pop_mchk;
    logic        clr_mchk;
    logic        clr_ext;
    logic        clr_tod;
    logic        clr_io;
  } irq_pick_t;

  function automatic logic [2:0] opcode_len(input logic [1:0] top);
    case (top)
      2'b00:   return 3'd2;
      2'b11:   return 3'd6;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/irqd_len.sv
module irqd_len
  import irqd_pkg::*;
(
  input  logic [2:0] len_code_i,
  input  logic [1:0] opc_top_i,
  output logic [2:0] len_o,
  output logic       inc_o
);
  always_comb begin
    inc_o = 1'b0;
    case (len_code_i)
      LEN_DEFER:     len_o = opcode_len(opc_top_i);
      LEN_DEFER_INC: begin
        len_o = opcode_len(opc_top_i);
        inc_o = 1'b1;
      end
      default:       len_o = len_code_i;
    endcase
  end
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
  import irqd_pkg::*;
#(
  parameter int NSUB = 8,
  parameter int CW   = 4
) (
  input  logic               pgm_exc_i,
  input  logic [15:0]        pgm_code_i,
  input  logic               svc_exc_i,
  input  logic [15:0]        svc_code_i,
  input  logic               en_mchk_i,
  input  logic               en_ext_i,
  input  logic               en_io_i,
  input  logic               pend_mchk_i,
  input  logic               pend_ext_i,
  input  logic               pend_tod_i,
  input  logic               pend_cpt_i,
  input  logic               pend_io_i,
  input  logic [NSUB-1:0]    io_enable_i,
  input  logic               mchk_gate_i,
  input  logic [CW-1:0]      mchk_cnt_i,
  input  logic [CW-1:0]      ext_cnt_i,
  input  logic [NSUB*CW-1:0] io_cnt_i,
  input  logic [15:0]        ext_code_i,
  output irq_pick_t          pick_o,
  output logic [NSUB-1:0]    io_pop_o
);
  logic [NSUB-1:0] io_has, io_last, io_ok;

  for (genvar k = 0; k < NSUB; k++) begin : g_sub
    assign io_has[k]  = io_cnt_i[k*CW +: CW] != '0;
    assign io_last[k] = io_cnt_i[k*CW +: CW] == CW'(1);
    assign io_ok[k]   = io_has[k] & io_enable_i[NSUB-1-k];
  end

  logic ext_queued;
  assign ext_queued = pend_ext_i && (ext_cnt_i != '0);

  logic            found;
  logic [NSUB-1:0] remain;

  always_comb begin
    pick_o     = '0;
    pick_o.cls = CLS_NONE;
    io_pop_o   = '0;
    found      = 1'b0;
    remain     = io_has;
    if (pgm_exc_i) begin
      pick_o.cls = CLS_PGM; pick_o.code = pgm_code_i; pick_o.deliver = 1'b1;
    end else if (svc_exc_i) begin
      pick_o.cls = CLS_SVC; pick_o.code = svc_code_i; pick_o.deliver = 1'b1;
    end else if (en_mchk_i && pend_mchk_i) begin
      if (mchk_gate_i && mchk_cnt_i != '0) begin
        pick_o.cls      = CLS_MCHK;
        pick_o.deliver  = 1'b1;
        pick_o.pop_mchk = 1'b1;
        pick_o.clr_mchk = mchk_cnt_i == CW'(1);
      end
    end else if (en_ext_i && (ext_queued || pend_tod_i || pend_cpt_i)) begin
      pick_o.cls     = CLS_EXT;
      pick_o.deliver = 1'b1;
      if (ext_queued) begin
        pick_o.code    = ext_code_i;
        pick_o.pop_ext = 1'b1;
        pick_o.clr_ext = ext_cnt_i == CW'(1);
      end else begin
        pick_o.code    = pend_tod_i ? CODE_CLKCMP : CODE_CPUTMR;
        pick_o.clr_ext = 1'b1;
        pick_o.clr_tod = 1'b1;
      end
    end else if (en_io_i && pend_io_i) begin
      for (int k = 0; k < NSUB; k++) begin
        if (!found && io_ok[k]) begin
          found          = 1'b1;
          io_pop_o[k]    = 1'b1;
          pick_o.code    = 16'(k);
          pick_o.cls     = CLS_IO;
          pick_o.deliver = 1'b1;
          if (io_last[k]) remain[k] = 1'b0;
        end
      end
      pick_o.clr_io = remain == '0;
    end
  end
endmodule

// File: rtl/irqd_mem_fsm.sv
module irqd_mem_fsm #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          deliver_i,
  input  logic [AW-1:0] base_i,
  input  logic [63:0]   param_i,
  input  logic [63:0]   omask_i,
  input  logic [63:0]   oaddr_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [63:0]   mem_wdata_o,
  input  logic          mem_rvalid_i,
  output logic          mem_rready_o,
  input  logic [63:0]   mem_rdata_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [63:0]   new_mask_o,
  output logic [63:0]   new_addr_o
);
  typedef enum logic [3:0] {
    S_IDLE, S_WPARM, S_WOMASK, S_WOADDR, S_RNMASK, S_WTMASK, S_RNADDR, S_WTADDR, S_DONE
  } st_e;

  st_e           st;
  logic [AW-1:0] base_q;
  logic [63:0]   param_q, omask_q, oaddr_q;
  logic          fire;

  assign idle_o       = st == S_IDLE;
  assign done_o       = st == S_DONE;
  assign mem_rready_o = st == S_WTMASK || st == S_WTADDR;
  assign fire         = mem_req_valid_o && mem_req_ready_i;

  always_comb begin
    mem_req_valid_o = 1'b1;
    mem_we_o        = 1'b1;
    mem_addr_o      = base_q;
    mem_wdata_o     = param_q;
    case (st)
      S_WPARM:  ;
      S_WOMASK: begin mem_addr_o = base_q + AW'(8);  mem_wdata_o = omask_q; end
      S_WOADDR: begin mem_addr_o = base_q + AW'(16); mem_wdata_o = oaddr_q; end
      S_RNMASK: begin mem_addr_o = base_q + AW'(24); mem_we_o = 1'b0; mem_wdata_o = '0; end
      S_RNADDR: begin mem_addr_o = base_q + AW'(32); mem_we_o = 1'b0; mem_wdata_o = '0; end
      default:  begin mem_req_valid_o = 1'b0; mem_we_o = 1'b0; mem_wdata_o = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      base_q     <= '0;
      param_q    <= '0;
      omask_q    <= '0;
      oaddr_q    <= '0;
      new_mask_o <= '0;
      new_addr_o <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          base_q  <= base_i;
          param_q <= param_i;
          omask_q <= omask_i;
          oaddr_q <= oaddr_i;
          st      <= deliver_i ? S_WPARM : S_DONE;
        end
        S_WPARM:  if (fire) st <= S_WOMASK;
        S_WOMASK: if (fire) st <= S_WOADDR;
        S_WOADDR: if (fire) st <= S_RNMASK;
        S_RNMASK: if (fire) st <= S_WTMASK;
        S_WTMASK: if (mem_rvalid_i) begin new_mask_o <= mem_rdata_i; st <= S_RNADDR; end
        S_RNADDR: if (fire) st <= S_WTADDR;
        S_WTADDR: if (mem_rvalid_i) begin new_addr_o <= mem_rdata_i; st <= S_DONE; end
        default:  st <= S_IDLE;
      endcase
    end
  end

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_we_o));

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r12_no_req_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_valid_o);
endmodule

// File: rtl/irq_delivery_seq.sv
module irq_delivery_seq
  import irqd_pkg::*;
#(
  parameter int            AW       = 12,
  parameter int            NSUB     = 8,
  parameter int            CW       = 4,
  parameter logic [AW-1:0] LOW_BASE = AW'(256)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic               pgm_exc_i,
  input  logic [15:0]        pgm_code_i,
  input  logic [2:0]         pgm_len_i,
  input  logic [1:0]         opc_top_i,
  input  logic               svc_exc_i,
  input  logic [15:0]        svc_code_i,
  input  logic [2:0]         svc_len_i,
  input  logic [63:0]        sw_mask_i,
  input  logic [63:0]        sw_addr_i,
  input  logic [1:0]         cc_i,
  input  logic               en_mchk_i,
  input  logic               en_ext_i,
  input  logic               en_io_i,
  input  logic               pend_mchk_i,
  input  logic               pend_ext_i,
  input  logic               pend_tod_i,
  input  logic               pend_cpt_i,
  input  logic               pend_io_i,
  input  logic [NSUB-1:0]    io_enable_i,
  input  logic               mchk_gate_i,
  input  logic [CW-1:0]      mchk_cnt_i,
  input  logic [CW-1:0]      ext_cnt_i,
  input  logic [NSUB*CW-1:0] io_cnt_i,
  input  logic [15:0]        ext_code_i,
  input  logic [7:0]         cpu_num_i,
  output logic               irq_req_o,
  output logic [2:0]         sel_class_o,
  output logic [15:0]        sel_code_o,
  output logic               mchk_pop_o,
  output logic               ext_pop_o,
  output logic [NSUB-1:0]    io_pop_o,
  output logic               clr_mchk_o,
  output logic               clr_ext_o,
  output logic               clr_tod_o,
  output logic               clr_io_o,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [63:0]        mem_wdata_o,
  input  logic               mem_rvalid_i,
  output logic               mem_rready_o,
  input  logic [63:0]        mem_rdata_i,
  output logic               done_o,
  output logic [63:0]        new_mask_o,
  output logic [63:0]        new_addr_o
);
  irq_pick_t       pick;
  logic [NSUB-1:0] io_pick;
  logic [2:0]      plen;
  logic            pinc, idle, accept;
  logic [63:0]     omask, oaddr, param;
  logic [AW-1:0]   base;

  assign irq_req_o = pend_mchk_i | pend_ext_i | pend_tod_i | pend_cpt_i | pend_io_i;
  assign accept    = take_i && idle;

  irqd_arbiter #(.NSUB(NSUB), .CW(CW)) u_arb (
    .pgm_exc_i, .pgm_code_i, .svc_exc_i, .svc_code_i,
    .en_mchk_i, .en_ext_i, .en_io_i,
    .pend_mchk_i, .pend_ext_i, .pend_tod_i, .pend_cpt_i, .pend_io_i,
    .io_enable_i, .mchk_gate_i, .mchk_cnt_i, .ext_cnt_i, .io_cnt_i, .ext_code_i,
    .pick_o(pick), .io_pop_o(io_pick)
  );

  irqd_len u_len (.len_code_i(pgm_len_i), .opc_top_i, .len_o(plen), .inc_o(pinc));

  always_comb begin
    omask = (sw_mask_i & ~(64'h3 << CC_LSB)) | (64'(cc_i) << CC_LSB);
    oaddr = sw_addr_i;
    param = {48'b0, pick.code};
    base  = LOW_BASE + AW'(pick.cls) * AW'(SLOT_STRIDE);
    case (pick.cls)
      CLS_PGM: begin
        param = {32'b0, 16'(plen), pick.code};
        if (pinc) oaddr = sw_addr_i + 64'(plen);
      end
      CLS_SVC: begin
        param = {32'b0, 16'(svc_len_i), pick.code};
        oaddr = sw_addr_i + 64'(svc_len_i);
      end
      CLS_EXT:  param = {16'b0, 16'(cpu_num_i) | CPU_ADDR_TAG, 16'b0, pick.code};
      CLS_MCHK: param = MCHK_PARAM;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_class_o <= CLS_NONE;
      sel_code_o  <= '0;
      mchk_pop_o  <= 1'b0;
      ext_pop_o   <= 1'b0;
      io_pop_o    <= '0;
      clr_mchk_o  <= 1'b0;
      clr_ext_o   <= 1'b0;
      clr_tod_o   <= 1'b0;
      clr_io_o    <= 1'b0;
    end else begin
      mchk_pop_o <= 1'b0;
      ext_pop_o  <= 1'b0;
      io_pop_o   <= '0;
      clr_mchk_o <= 1'b0;
      clr_ext_o  <= 1'b0;
      clr_tod_o  <= 1'b0;
      clr_io_o   <= 1'b0;
      if (accept) begin
        sel_class_o <= pick.cls;
        sel_code_o  <= pick.code;
        mchk_pop_o  <= pick.pop_mchk;
        ext_pop_o   <= pick.pop_ext;
        io_pop_o    <= io_pick;
        clr_mchk_o  <= pick.clr_mchk;
        clr_ext_o   <= pick.clr_ext;
        clr_tod_o   <= pick.clr_tod;
        clr_io_o    <= pick.clr_io;
      end
    end
  end

  irqd_mem_fsm #(.AW(AW)) u_fsm (
    .clk, .rst_n, .start_i(accept), .deliver_i(pick.deliver),
    .base_i(base), .param_i(param), .omask_i(omask), .oaddr_i(oaddr),
    .mem_req_valid_o, .mem_req_ready_i, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rvalid_i, .mem_rready_o, .mem_rdata_i,
    .idle_o(idle), .done_o, .new_mask_o, .new_addr_o
  );

  a_r3_io_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(io_pop_o));

  a_r5_mchk_gate: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_pop_o |-> $past(mchk_gate_i));

  a_r2_timer_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tod_o |-> !ext_pop_o && clr_ext_o);

  a_r9_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    accept && pgm_exc_i |-> pgm_len_i inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd6});
endmodule

// File: tb/irq_delivery_seq_tb.sv
module irq_delivery_seq_tb;
  localparam int AW = 12, NSUB = 8, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic take, pgm, svc, em, ee, ei, pm, pe, pt, pc, pi, gate;
  logic [15:0] pgm_code, svc_code, ext_code;
  logic [2:0] pgm_len, svc_len;
  logic [1:0] opc, cc;
  logic [63:0] sw_mask, sw_addr;
  logic [NSUB-1:0] io_en;
  logic [CW-1:0] mcnt, ecnt;
  logic [NSUB*CW-1:0] icnt;
  logic [7:0] cpu_num;
  logic irq_req, mpop, epop, cm, ce, ct, ci, mvalid, mwe, mrready, done, stall;
  logic [2:0] cls;
  logic [15:0] code;
  logic [NSUB-1:0] ipop;
  logic [AW-1:0] maddr;
  logic [63:0] mwdata, nmask, naddr;
  logic mrvalid = 1'b0;
  logic [63:0] mrdata = '0;
  logic [63:0] mem [512];

  irq_delivery_seq #(.AW(AW), .NSUB(NSUB), .CW(CW)) u_dut (
    .clk, .rst_n, .take_i(take), .pgm_exc_i(pgm), .pgm_code_i(pgm_code),
    .pgm_len_i(pgm_len), .opc_top_i(opc), .svc_exc_i(svc), .svc_code_i(svc_code),
    .svc_len_i(svc_len), .sw_mask_i(sw_mask), .sw_addr_i(sw_addr), .cc_i(cc),
    .en_mchk_i(em), .en_ext_i(ee), .en_io_i(ei), .pend_mchk_i(pm), .pend_ext_i(pe),
    .pend_tod_i(pt), .pend_cpt_i(pc), .pend_io_i(pi), .io_enable_i(io_en),
    .mchk_gate_i(gate), .mchk_cnt_i(mcnt), .ext_cnt_i(ecnt), .io_cnt_i(icnt),
    .ext_code_i(ext_code), .cpu_num_i(cpu_num), .irq_req_o(irq_req),
    .sel_class_o(cls), .sel_code_o(code), .mchk_pop_o(mpop), .ext_pop_o(epop),
    .io_pop_o(ipop), .clr_mchk_o(cm), .clr_ext_o(ce), .clr_tod_o(ct), .clr_io_o(ci),
    .mem_req_valid_o(mvalid), .mem_req_ready_i(!stall), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rvalid_i(mrvalid),
    .mem_rready_o(mrready), .mem_rdata_i(mrdata), .done_o(done),
    .new_mask_o(nmask), .new_addr_o(naddr)
  );

  function automatic logic [63:0] rd_pat(input logic [AW-1:0] a);
    return 64'hA5A5_0000_0000_0000 | 64'(a);
  endfunction

  always @(posedge clk) begin
    if (mvalid && !stall && mwe) mem[maddr[11:3]] <= mwdata;
    if (mvalid && !stall && !mwe) begin
      mrvalid <= 1'b1;
      mrdata  <= rd_pat(maddr);
    end else if (mrvalid && mrready) mrvalid <= 1'b0;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    take = 0; pgm = 0; svc = 0; em = 1; ee = 1; ei = 1;
    pm = 0; pe = 0; pt = 0; pc = 0; pi = 0; gate = 1;
    pgm_code = 16'h0011; svc_code = 16'h0042; ext_code = 16'h2401;
    pgm_len = 3'd2; svc_len = 3'd4; opc = 2'b00; cc = 2'b00;
    sw_mask = '0; sw_addr = 64'h1000; io_en = '1; mcnt = '0; ecnt = '0; icnt = '0;
    cpu_num = 8'd5;
  endtask

  task automatic pulse_take();
    take = 1'b1;
    @(negedge clk);
    take = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    chk({tag, " done pulse"}, done, 1'b1);
    @(negedge clk);
  endtask

  // sync{pgm,svc} en{m,e,i} pend{m,e,tod,cpt,io} gate en_sub ioq qn | cls code clr{m,e,tod,io}
  localparam int NV = 16;
  localparam logic [53:0] VEC [NV] = '{
    {2'b00,3'b111,5'b00000,1'b1,8'hFF,8'h00,4'd0,3'd0,16'h0000,4'b0000},
    {2'b10,3'b111,5'b11001,1'b1,8'hFF,8'h01,4'd1,3'd1,16'h0011,4'b0000},
    {2'b01,3'b000,5'b00000,1'b1,8'hFF,8'h00,4'd0,3'd2,16'h0042,4'b0000},
    {2'b00,3'b111,5'b11001,1'b1,8'hFF,8'h01,4'd1,3'd3,16'h0000,4'b1000},
    {2'b00,3'b011,5'b11001,1'b1,8'hFF,8'h01,4'd1,3'd4,16'h2401,4'b0100},
    {2'b00,3'b111,5'b11001,1'b0,8'hFF,8'h01,4'd1,3'd0,16'h0000,4'b0000},
    {2'b00,3'b111,5'b01000,1'b1,8'hFF,8'h00,4'd2,3'd4,16'h2401,4'b0000},
    {2'b00,3'b111,5'b00110,1'b1,8'hFF,8'h00,4'd0,3'd4,16'h1004,4'b0110},
    {2'b00,3'b111,5'b00010,1'b1,8'hFF,8'h00,4'd0,3'd4,16'h1005,4'b0110},
    {2'b00,3'b101,5'b01001,1'b1,8'hFF,8'h14,4'd1,3'd5,16'h0002,4'b0000},
    {2'b00,3'b001,5'b00001,1'b1,8'hFF,8'h04,4'd1,3'd5,16'h0002,4'b0001},
    {2'b00,3'b001,5'b00001,1'b1,8'hFE,8'h05,4'd1,3'd5,16'h0002,4'b0000},
    {2'b00,3'b001,5'b00001,1'b1,8'hFE,8'h01,4'd1,3'd0,16'h0000,4'b0000},
    {2'b00,3'b001,5'b00001,1'b1,8'hFF,8'h00,4'd0,3'd0,16'h0000,4'b0001},
    {2'b00,3'b110,5'b00001,1'b1,8'hFF,8'h08,4'd1,3'd0,16'h0000,4'b0000},
    {2'b00,3'b001,5'b00001,1'b1,8'hFF,8'h08,4'd2,3'd5,16'h0003,4'b0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    stall = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state, R11 request low with nothing pending
    chk("R14 class after reset", cls, 3'd0);
    chk("R14 done after reset", done, 1'b0);
    chk("R14 mem valid after reset", mvalid, 1'b0);
    chk("R14 strobes after reset", {mpop, epop, ipop, cm, ce, ct, ci}, '0);
    chk("R11 request idle", irq_req, 1'b0);
    pt = 1'b1; #1;
    chk("R11 request on timer flag", irq_req, 1'b1);
    pt = 1'b0; pi = 1'b1; #1;
    chk("R11 request on io flag", irq_req, 1'b1);
    pi = 1'b0;

    // Table: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      logic [53:0] t;
      logic [2:0] ecls;
      logic [15:0] ecode;
      logic [NSUB-1:0] eio;
      t = VEC[v];
      idle_inputs();
      {pgm, svc} = t[53:52];
      {em, ee, ei} = t[51:49];
      {pm, pe, pt, pc, pi} = t[48:44];
      gate = t[43];
      for (int k = 0; k < NSUB; k++) begin
        io_en[NSUB-1-k] = t[35+k];
        icnt[k*CW +: CW] = t[27+k] ? t[26:23] : '0;
      end
      ecnt = pe ? t[26:23] : '0;
      mcnt = pm ? t[26:23] : '0;
      ecls = t[22:20];
      ecode = t[19:4];
      eio = (ecls == 3'd5) ? NSUB'(1) << ecode : '0;
      pulse_take();
      chk($sformatf("R1 class row %0d", v), cls, ecls);
      chk($sformatf("R2 R3 code row %0d", v), code, ecode);
      chk($sformatf("R4 R5 R6 clears row %0d", v), {cm, ce, ct, ci}, t[3:0]);
      chk($sformatf("R3 io pops row %0d", v), ipop, eio);
      chk($sformatf("R6 pops row %0d", v), {mpop, epop},
          {ecls == 3'd3, ecls == 3'd4 && ecode == 16'h2401});
      wait_done($sformatf("R12 row %0d", v));
    end

    // R7 R9 R12: deferred length with increment, opcode top 11 -> 6
    idle_inputs();
    pgm = 1; pgm_len = 3'd1; opc = 2'b11; cc = 2'b01;
    sw_mask = 64'h0000_3000_0000_0001;
    pulse_take();
    wait_done("R12 pgm inc");
    chk("R9 pgm param len 6", mem[12'h140 >> 3], 64'h0000_0000_0006_0011);
    chk("R7 old mask cc merge", mem[12'h148 >> 3], 64'h0000_1000_0000_0001);
    chk("R9 old addr plus 6", mem[12'h150 >> 3], 64'h1006);
    chk("R12 new mask read", nmask, rd_pat(12'h158));
    chk("R12 new addr read", naddr, rd_pat(12'h160));

    // R9 deferred without increment, opcode top 01 -> 4
    idle_inputs();
    pgm = 1; pgm_len = 3'd0; opc = 2'b01; cc = 2'b10; sw_mask = '1;
    pulse_take();
    wait_done("R12 pgm defer");
    chk("R9 pgm param len 4", mem[12'h140 >> 3], 64'h0000_0000_0004_0011);
    chk("R9 old addr unchanged", mem[12'h150 >> 3], 64'h1000);
    chk("R7 old mask cc 10", mem[12'h148 >> 3], 64'hFFFF_EFFF_FFFF_FFFF);

    // R9 direct length ignores opcode
    idle_inputs();
    pgm = 1; pgm_len = 3'd4; opc = 2'b11;
    pulse_take();
    wait_done("R12 pgm direct");
    chk("R9 direct len 4", mem[12'h140 >> 3], 64'h0000_0000_0004_0011);

    // R8 supervisor call
    idle_inputs();
    svc = 1; svc_len = 3'd6;
    pulse_take();
    wait_done("R12 svc");
    chk("R8 svc param", mem[12'h180 >> 3], 64'h0000_0000_0006_0042);
    chk("R8 svc old addr", mem[12'h190 >> 3], 64'h1006);

    // R10 external cpu address and machine-check word
    idle_inputs();
    pt = 1;
    pulse_take();
    wait_done("R12 ext");
    chk("R10 ext param", mem[12'h200 >> 3], 64'h0000_0D05_0000_1004);
    idle_inputs();
    pm = 1; mcnt = 4'd3;
    pulse_take();
    chk("R6 mchk count 3 no clear", {mpop, cm}, 2'b10);
    wait_done("R12 mchk");
    chk("R10 mchk param", mem[12'h1C0 >> 3], 64'h00400F1D_40330000);

    // R13 stall holds request, second take ignored
    idle_inputs();
    stall = 1'b1;
    pgm = 1;
    pulse_take();
    repeat (4) @(negedge clk);
    chk("R13 request held valid", mvalid, 1'b1);
    chk("R13 request addr held", maddr, 12'h140);
    chk("R13 request write held", mwe, 1'b1);
    pgm = 0; svc = 1;
    pulse_take();
    chk("R13 take ignored class", cls, 3'd1);
    chk("R13 take ignored addr", maddr, 12'h140);
    svc = 0;
    stall = 1'b0;
    wait_done("R13 after stall");
    chk("R13 class after stall", cls, 3'd1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule